// File: doc/BRIEF.md
# Interrupt and Bus-Error Status Unit

This block is the interrupt register file of a disk-interface function. It keeps two pending sources: a device interrupt and a host-bus error seen while the DMA engine was moving data. Each source has a sticky enable bit. One level-sensitive interrupt line is high while any pending source is also enabled. Software reads the pending bits from one word and clears them by writing ones to a second word. It turns sources on by writing ones to a third word. When a bus error arrives and no earlier error is still pending, the 64-bit faulting address is captured into two readable words.

The bus master that detects errors and the attached device are outside the block. Each appears as a single-cycle event input, and the bus-error event comes with an address. Register access is a plain single-cycle write strobe with a word index and a two-bit mask of ones. Reads are a combinational mux selected by a separate read index. There is no data stream at the block's edge, so no valid/ready handshake is used.

Top module: `intr_err_status`

## Requirements
- R1: After reset the pending bits, the enable bits and both captured-address words read as zero, and `irq_o` is low.
- R2: A pulse on `dev_evt_i` sets pending bit 0. The pending word is read at word index 3, with bit 0 the device source, bit 1 the bus-error source and all other bits zero.
- R3: A pulse on `bus_err_evt_i` sets pending bit 1.
- R4: A write to word index 7 clears each pending bit whose mask bit is 1. Pending bits whose mask bit is 0 are left unchanged.
- R5: A write to word index 5 sets each enable bit whose mask bit is 1. Zeros in the mask leave enables unchanged. Enables read back at word index 5, bits [1:0].
- R6: `irq_o` is high exactly when some pending bit and its enable bit are both 1. It rises in the cycle after an event on an enabled source.
- R7: When a source event and a clear write for the same bit fall in one cycle, the bit ends up set.
- R8: A bus-error event while pending bit 1 is 0 captures address bits [31:0] into word index 0 and bits [63:32] into word index 1.
- R9: A bus-error event while pending bit 1 is 1 leaves the captured address unchanged. After bit 1 is cleared, the next error captures again.
- R10: Pending bits latch whether or not their source is enabled. A masked pending bit does not drive `irq_o`, and enabling it later raises `irq_o` on the next cycle.
- R11: Writes to word indices other than 5 and 7 change no state. Reads of indices 2, 4 and 6 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Word index of the write |
| wr_mask_i | input | 2 | Ones select the sources affected by the write |
| rd_idx_i | input | 3 | Word index of the read |
| rd_data_o | output | 32 | Read data for `rd_idx_i` (combinational) |
| dev_evt_i | input | 1 | One-cycle device interrupt event |
| bus_err_evt_i | input | 1 | One-cycle host-bus DMA error event |
| bus_err_addr_i | input | 64 | Faulting address, valid with `bus_err_evt_i` |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that the event inputs and the write strobe are sampled as clean levels at each rising edge. They also assume that `bus_err_addr_i` is meaningful only in a cycle where `bus_err_evt_i` is high. The bench drives every input on the falling edge and pulses each event for exactly one cycle. It holds the address steady across the event cycle, so the capture check compares against the value presented with the event. Coincident clear-and-event cycles are produced on purpose to exercise the priority rule.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 64;

  localparam logic [IDX_W-1:0] IDX_ADDR_LO = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_HI = 3'd1;
  localparam logic [IDX_W-1:0] IDX_PEND    = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ENSET   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_CLEAR   = 3'd7;

  localparam int unsigned SRC_DEV = 0;
  localparam int unsigned SRC_ERR = 1;
endpackage

// File: rtl/src_latch.sv
module src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_set_i,
  output logic pend_o,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      if (evt_i)      pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
      if (en_set_i)   en_o   <= 1'b1;
    end
  end

  a_r7_event_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> pend_o);
  a_r4_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !pend_o);
  a_r5_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o || en_set_i) |=> en_o);
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !evt_i) |=> !pend_o);
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              err_pend_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic take;
  assign take = evt_i && !err_pend_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (take) begin
      lo_o <= addr_i[HALF_W-1:0];
      hi_o <= addr_i[ADDR_W-1:HALF_W];
    end
  end

  a_r8_first_error_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !err_pend_i) |=> ({hi_o, lo_o} == $past(addr_i)));
  a_r9_later_error_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend_i |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

// File: rtl/intr_err_status.sv
module intr_err_status
  import intr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [NSRC-1:0]   wr_mask_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              dev_evt_i,
  input  logic              bus_err_evt_i,
  input  logic [ADDR_W-1:0] bus_err_addr_i,
  output logic              irq_o
);
  localparam int unsigned HALF_W = ADDR_W / 2;

  logic [NSRC-1:0]   evt, clr, en_set, pend_q, en_q;
  logic [HALF_W-1:0] cap_lo, cap_hi;

  assign evt[SRC_DEV] = dev_evt_i;
  assign evt[SRC_ERR] = bus_err_evt_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign clr[g]    = wr_en_i && (wr_idx_i == IDX_CLEAR) && wr_mask_i[g];
    assign en_set[g] = wr_en_i && (wr_idx_i == IDX_ENSET) && wr_mask_i[g];
    src_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt[g]),
      .clr_i    (clr[g]),
      .en_set_i (en_set[g]),
      .pend_o   (pend_q[g]),
      .en_o     (en_q[g])
    );
  end

  err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (bus_err_evt_i),
    .err_pend_i (pend_q[SRC_ERR]),
    .addr_i     (bus_err_addr_i),
    .lo_o       (cap_lo),
    .hi_o       (cap_hi)
  );

  assign irq_o = |(pend_q & en_q);

  always_comb begin
    rd_data_o = '0;
    case (rd_idx_i)
      IDX_ADDR_LO: rd_data_o[HALF_W-1:0] = cap_lo;
      IDX_ADDR_HI: rd_data_o[HALF_W-1:0] = cap_hi;
      IDX_PEND:    rd_data_o[NSRC-1:0]   = pend_q;
      IDX_ENSET:   rd_data_o[NSRC-1:0]   = en_q;
      default:     rd_data_o = '0;
    endcase
  end

  a_r6_irq_rises_on_enabled_event: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_evt_i && en_q[SRC_DEV]) |=> irq_o);
  a_r11_other_writes_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != IDX_CLEAR && wr_idx_i != IDX_ENSET && !dev_evt_i && !bus_err_evt_i)
    |=> ($stable(pend_q) && $stable(en_q)));
endmodule

// File: tb/test_intr_err_status.sv
module test_intr_err_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_mask;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;
  logic        dev_evt, err_evt;
  logic [63:0] err_addr;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intr_err_status i_intr_err_status (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_mask_i(wr_mask),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .dev_evt_i(dev_evt), .bus_err_evt_i(err_evt),
    .bus_err_addr_i(err_addr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; one rising edge passes
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; dev_evt = 1'b0; err_evt = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    rd_idx = idx;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [1:0] m);
    wr_en = 1'b1; wr_idx = idx; wr_mask = m;
    cycle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_mask = '0; rd_idx = '0;
    dev_evt = 1'b0; err_evt = 1'b0; err_addr = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(3'd3, v); chk("R1 pending", v, 32'h0);
    rd(3'd5, v); chk("R1 enable", v, 32'h0);
    rd(3'd0, v); chk("R1 addr lo", v, 32'h0);
    rd(3'd1, v); chk("R1 addr hi", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_sources();
    logic [31:0] v;
    do_reset();
    dev_evt = 1'b1; cycle();
    rd(3'd3, v); chk("R2 device pending", v, 32'h1);
    chk("R10 masked irq low", {31'd0, irq}, 32'h0);
    err_addr = 64'h1234_5678_9ABC_DEF0; err_evt = 1'b1; cycle();
    rd(3'd3, v); chk("R3 error pending", v, 32'h3);
    rd(3'd0, v); chk("R8 addr lo", v, 32'h9ABC_DEF0);
    rd(3'd1, v); chk("R8 addr hi", v, 32'h1234_5678);
    wr(3'd7, 2'b01);
    rd(3'd3, v); chk("R4 clear bit0 only", v, 32'h2);
    wr(3'd7, 2'b10);
    rd(3'd3, v); chk("R4 clear bit1", v, 32'h0);
  endtask

  task automatic t_enable_irq();
    logic [31:0] v;
    do_reset();
    err_addr = 64'h0; err_evt = 1'b1; cycle();
    chk("R10 pending but masked", {31'd0, irq}, 32'h0);
    wr(3'd5, 2'b01);
    rd(3'd5, v); chk("R5 enable bit0", v, 32'h1);
    chk("R6 device enabled not pending", {31'd0, irq}, 32'h0);
    wr(3'd5, 2'b10);
    rd(3'd5, v); chk("R5 enable sticky", v, 32'h3);
    chk("R10 late enable raises irq", {31'd0, irq}, 32'h1);
    wr(3'd7, 2'b10);
    chk("R6 irq drops on clear", {31'd0, irq}, 32'h0);
    dev_evt = 1'b1; cycle();
    chk("R6 irq after enabled event", {31'd0, irq}, 32'h1);
    wr(3'd5, 2'b00);
    rd(3'd5, v); chk("R5 zero mask no change", v, 32'h3);
  endtask

  task automatic t_race();
    logic [31:0] v;
    do_reset();
    dev_evt = 1'b1; cycle();
    dev_evt = 1'b1; wr_en = 1'b1; wr_idx = 3'd7; wr_mask = 2'b11; cycle();
    rd(3'd3, v); chk("R7 event beats clear", v, 32'h1);
  endtask

  task automatic t_capture_hold();
    logic [31:0] v;
    do_reset();
    err_addr = 64'hAAAA_0001_BBBB_0002; err_evt = 1'b1; cycle();
    err_addr = 64'hCCCC_0003_DDDD_0004; err_evt = 1'b1; cycle();
    rd(3'd0, v); chk("R9 lo held", v, 32'hBBBB_0002);
    rd(3'd1, v); chk("R9 hi held", v, 32'hAAAA_0001);
    wr(3'd7, 2'b10);
    err_addr = 64'hEEEE_0005_FFFF_0006; err_evt = 1'b1; cycle();
    rd(3'd0, v); chk("R9 recapture lo", v, 32'hFFFF_0006);
    rd(3'd1, v); chk("R9 recapture hi", v, 32'hEEEE_0005);
  endtask

  task automatic t_other_idx();
    logic [31:0] v;
    do_reset();
    dev_evt = 1'b1; cycle();
    for (int i = 0; i < 8; i++) begin
      if (i != 5 && i != 7) wr(3'(i), 2'b11);
    end
    rd(3'd3, v); chk("R11 pending unchanged", v, 32'h1);
    rd(3'd5, v); chk("R11 enable unchanged", v, 32'h0);
    rd(3'd2, v); chk("R11 idx2 zero", v, 32'h0);
    rd(3'd4, v); chk("R11 idx4 zero", v, 32'h0);
    rd(3'd6, v); chk("R11 idx6 zero", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_sources();
    t_enable_irq();
    t_race();
    t_capture_hold();
    t_other_idx();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule